// File: doc/BRIEF.md
# AHB Bus Error Monitor

This block sits beside an AMBA AHB bus as a passive observer. For every transfer it records the address, direction, size and master index presented in the address phase, and it keeps that record for the transfer's data phase. Two sources of faults are counted. The first is an ERROR response from a slave. The second is a one-bit pulse that EDAC-protected slaves raise when they have repaired a single-bit fault. Each source has its own counter and its own programmable threshold.

When a count goes past its threshold, the block freezes the record of the transfer involved and sets a new-error status flag. A correctable-error flag is also set when the correctable counter caused the event. A one-cycle interrupt pulse is raised at the same time. Software reads the frozen record through a small register port and clears the flags with write-one-to-clear. Counting and capture start again only when both flags are clear.

Top module: `ahb_err_monitor`

## Requirements
- R1: After reset the status word, the failing address, both thresholds and `irq` are all zero, so the first counted fault trips at once.
- R2: The recorded attributes belong to the transfer whose data phase faulted. They are captured in its address phase, even when the next transfer's address phase overlaps that data phase. The status word holds new-error at bit 0, correctable at bit 1, write at bit 2, size at bits 6:4 and master at bits 8+MASTER_W-1:8.
- R3: An ERROR response (`hresp` = 2'b01) counts only in its first cycle, with `hready` low, and only while a transfer (`htrans[1]` = 1 when accepted) is in its data phase. A lone cycle with `hresp` = 01 and `hready` high, or an ERROR with no transfer pending, is not counted.
- R4: With uncorrectable threshold T, the (T+1)-th counted ERROR sets new-error. The tripping counter then restarts from zero.
- R5: A `ce_in` pulse is counted, one per cycle high, against the correctable threshold. Passing that threshold sets both new-error and correctable.
- R6: The two counters are independent. ERROR responses never advance the correctable counter, and `ce_in` pulses never advance the uncorrectable counter.
- R7: While new-error or correctable is set, the record does not change and faults are neither counted nor recorded.
- R8: Writing the status offset with bit 0 set clears new-error, and with bit 1 set clears correctable. Monitoring resumes only when both are clear.
- R9: `irq` is high for exactly one cycle. That cycle directly follows the clock edge at which new-error or correctable rose.
- R10: Register offsets are 0 for status, 1 for failing address, 2 for the uncorrectable threshold and 3 for the correctable threshold. A threshold reads back its low CNT_W bits, with zeros above.
- R11: When both counters pass their thresholds in the same cycle, both flags are set, one `irq` pulse is raised, and both counters restart. When only one counter passes, only its flags are set and the other keeps its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| htrans | input | 2 | Observed transfer type |
| hready | input | 1 | Observed transfer-done signal |
| haddr | input | ADDR_W | Observed address |
| hwrite | input | 1 | Observed direction, 1 = write |
| hsize | input | 3 | Observed transfer size |
| hmaster | input | MASTER_W | Observed master index |
| hresp | input | 2 | Observed slave response |
| ce_in | input | 1 | Correctable-error pulse from EDAC slaves |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
An ERROR response and a correctable pulse can reach their thresholds in the same clock cycle. The bench provokes this by raising `ce_in` during the first cycle of an ERROR response. It runs the case twice: once with both thresholds at zero, and once with only the uncorrectable one able to trip. In each run it checks the flag pattern and the single `irq` pulse. It then sends single faults of each kind and checks which counter restarted and which one kept its count.

// File: rtl/ahbem_pkg.sv
package ahbem_pkg;

   localparam int REG_W  = 32;
   localparam int REG_AW = 2;
   localparam int NKIND  = 2;
   localparam int KIND_UE = 0;
   localparam int KIND_CE = 1;

   typedef enum logic [REG_AW-1:0] {
      REG_STATUS   = 2'd0,
      REG_FAILADDR = 2'd1,
      REG_UE_THR   = 2'd2,
      REG_CE_THR   = 2'd3
   } reg_sel_e;

   localparam int ST_NE       = 0;
   localparam int ST_CE       = 1;
   localparam int ST_WR       = 2;
   localparam int ST_SIZE_LSB = 4;
   localparam int ST_MST_LSB  = 8;

   localparam logic [1:0] HRESP_ERROR  = 2'b01;
   localparam int         HTRANS_ACT_BIT = 1;

endpackage

// File: rtl/ahbem_capture.sv
module ahbem_capture #(
   parameter int ADDR_W   = 32,
   parameter int MASTER_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          htrans,
   input  logic                hready,
   input  logic [ADDR_W-1:0]   haddr,
   input  logic                hwrite,
   input  logic [2:0]          hsize,
   input  logic [MASTER_W-1:0] hmaster,
   input  logic [1:0]          hresp,
   output logic [ADDR_W-1:0]   dp_addr,
   output logic                dp_write,
   output logic [2:0]          dp_size,
   output logic [MASTER_W-1:0] dp_master,
   output logic                ue_evt
);
   import ahbem_pkg::*;

   logic dp_valid;
   logic accept;

   assign accept = hready & htrans[HTRANS_ACT_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_valid <= 1'b0;
      end else if (hready) begin
         dp_valid <= htrans[HTRANS_ACT_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_addr   <= '0;
         dp_write  <= 1'b0;
         dp_size   <= '0;
         dp_master <= '0;
      end else if (accept) begin
         dp_addr   <= haddr;
         dp_write  <= hwrite;
         dp_size   <= hsize;
         dp_master <= hmaster;
      end
   end

   // first cycle of the two-cycle ERROR response: hready still low
   assign ue_evt = dp_valid & (hresp == HRESP_ERROR) & ~hready;

endmodule

// File: rtl/ahbem_err_counter.sv
module ahbem_err_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic             hold,
   input  logic [CNT_W-1:0] thresh,
   output logic             trip
);
   logic [CNT_W-1:0] cnt_q;
   logic             accept;

   assign accept = evt & ~hold;
   // new count would exceed the threshold; cnt_q < thresh otherwise, so no wrap
   assign trip   = accept & (cnt_q >= thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (trip) begin
         cnt_q <= '0;
      end else if (accept) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ahb_err_monitor.sv
module ahb_err_monitor #(
   parameter int ADDR_W   = 32,
   parameter int MASTER_W = 4,
   parameter int CNT_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          htrans,
   input  logic                hready,
   input  logic [ADDR_W-1:0]   haddr,
   input  logic                hwrite,
   input  logic [2:0]          hsize,
   input  logic [MASTER_W-1:0] hmaster,
   input  logic [1:0]          hresp,
   input  logic                ce_in,
   input  logic [1:0]          reg_addr,
   input  logic                reg_wr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                irq
);
   import ahbem_pkg::*;

   if (ADDR_W < 1 || ADDR_W > REG_W) begin : g_bad_addr_w
      $error("ahb_err_monitor: ADDR_W must lie in 1..32");
   end
   if (MASTER_W < 1 || MASTER_W > REG_W - ST_MST_LSB) begin : g_bad_master_w
      $error("ahb_err_monitor: MASTER_W must lie in 1..24");
   end
   if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_cnt_w
      $error("ahb_err_monitor: CNT_W must lie in 1..32");
   end

   logic [ADDR_W-1:0]   dp_addr;
   logic                dp_write;
   logic [2:0]          dp_size;
   logic [MASTER_W-1:0] dp_master;
   logic                ue_evt;

   logic [NKIND-1:0]    evt;
   logic [NKIND-1:0]    trip;
   logic [CNT_W-1:0]    thr_rd [NKIND];

   logic                st_ne;
   logic                st_ce;
   logic                frozen;
   logic                any_trip;
   logic                stat_wr;

   logic [ADDR_W-1:0]   rec_addr;
   logic                rec_write;
   logic [2:0]          rec_size;
   logic [MASTER_W-1:0] rec_master;

   ahbem_capture #(
      .ADDR_W   (ADDR_W),
      .MASTER_W (MASTER_W)
   ) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .htrans    (htrans),
      .hready    (hready),
      .haddr     (haddr),
      .hwrite    (hwrite),
      .hsize     (hsize),
      .hmaster   (hmaster),
      .hresp     (hresp),
      .dp_addr   (dp_addr),
      .dp_write  (dp_write),
      .dp_size   (dp_size),
      .dp_master (dp_master),
      .ue_evt    (ue_evt)
   );

   assign evt[KIND_UE] = ue_evt;
   assign evt[KIND_CE] = ce_in;
   assign frozen       = st_ne | st_ce;

   for (genvar k = 0; k < NKIND; k++) begin : g_kind
      localparam reg_sel_e THR_SEL = (k == KIND_UE) ? REG_UE_THR : REG_CE_THR;
      logic [CNT_W-1:0] thr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            thr_q <= '0;
         end else if (reg_wr && (reg_addr == THR_SEL)) begin
            thr_q <= reg_wdata[CNT_W-1:0];
         end
      end

      assign thr_rd[k] = thr_q;

      ahbem_err_counter #(
         .CNT_W (CNT_W)
      ) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt    (evt[k]),
         .hold   (frozen),
         .thresh (thr_q),
         .trip   (trip[k])
      );
   end

   assign any_trip = |trip;
   assign stat_wr  = reg_wr && (reg_addr == REG_STATUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_ne <= 1'b0;
         st_ce <= 1'b0;
      end else if (any_trip) begin
         st_ne <= 1'b1;
         if (trip[KIND_CE]) st_ce <= 1'b1;
      end else if (stat_wr) begin
         if (reg_wdata[ST_NE]) st_ne <= 1'b0;
         if (reg_wdata[ST_CE]) st_ce <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_addr   <= '0;
         rec_write  <= 1'b0;
         rec_size   <= '0;
         rec_master <= '0;
      end else if (any_trip) begin
         rec_addr   <= dp_addr;
         rec_write  <= dp_write;
         rec_size   <= dp_size;
         rec_master <= dp_master;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= any_trip;
   end

   logic [REG_W-1:0] stat_word;
   logic [REG_W-1:0] addr_word;
   logic [REG_W-1:0] ue_thr_word;
   logic [REG_W-1:0] ce_thr_word;

   always_comb begin
      stat_word = '0;
      stat_word[ST_NE] = st_ne;
      stat_word[ST_CE] = st_ce;
      stat_word[ST_WR] = rec_write;
      stat_word[ST_SIZE_LSB +: 3]        = rec_size;
      stat_word[ST_MST_LSB +: MASTER_W]  = rec_master;
      addr_word = '0;
      addr_word[ADDR_W-1:0] = rec_addr;
      ue_thr_word = '0;
      ue_thr_word[CNT_W-1:0] = thr_rd[KIND_UE];
      ce_thr_word = '0;
      ce_thr_word[CNT_W-1:0] = thr_rd[KIND_CE];
   end

   always_comb begin
      case (reg_sel_e'(reg_addr))
         REG_STATUS:   reg_rdata = stat_word;
         REG_FAILADDR: reg_rdata = addr_word;
         REG_UE_THR:   reg_rdata = ue_thr_word;
         REG_CE_THR:   reg_rdata = ce_thr_word;
         default:      reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/ahb_err_monitor_chk.sv
module ahb_err_monitor_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              ne,
   input logic              ce,
   input logic [ADDR_W-1:0] fail_addr
);

   AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);                                                   // R9

   AST_IRQ_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($rose(ne) || $rose(ce)));                               // R9

   AST_NE_RISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ne) |-> irq);                                              // R9

   AST_CE_BRINGS_NE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ce) |-> ne);                                               // R5

   AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      ((ne || ce) && $past(ne || ce)) |-> $stable(fail_addr));         // R7

endmodule

bind ahb_err_monitor ahb_err_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq       (irq),
   .ne        (st_ne),
   .ce        (st_ce),
   .fail_addr (rec_addr)
);

// File: tb/ahb_err_monitor_tb.sv
module ahb_err_monitor_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W   = 32;
   localparam int MASTER_W = 4;
   localparam int CNT_W    = 8;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [1:0]          htrans = 2'b00;
   logic                hready = 1'b1;
   logic [ADDR_W-1:0]   haddr = '0;
   logic                hwrite = 1'b0;
   logic [2:0]          hsize = '0;
   logic [MASTER_W-1:0] hmaster = '0;
   logic [1:0]          hresp = 2'b00;
   logic                ce_in = 1'b0;
   logic [1:0]          reg_addr = 2'd0;
   logic                reg_wr = 1'b0;
   logic [31:0]         reg_wdata = '0;
   logic [31:0]         reg_rdata;
   logic                irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   ahb_err_monitor #(.ADDR_W(ADDR_W), .MASTER_W(MASTER_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .htrans(htrans), .hready(hready), .haddr(haddr),
      .hwrite(hwrite), .hsize(hsize), .hmaster(hmaster), .hresp(hresp), .ce_in(ce_in),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];
   bit    sample_req = 1'b0;
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   // status word layout from R2
   function automatic logic [31:0] stat(input bit ne, input bit ce, input bit w,
                                        input int sz, input int m);
      return (32'(m) << 8) | (32'(sz) << 4) | (32'(w) << 2) | (32'(ce) << 1) | 32'(ne);
   endfunction

   // monitor: pops expected items and compares away from the active edge
   always @(negedge clk) begin
      if (sample_req && sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it  = sb_q.pop_front();
         act = it.is_irq ? {31'b0, irq} : reg_rdata;
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic chk(input bit is_irq, input logic [1:0] a, input logic [31:0] exp,
                      input string tag);
      item_t it;
      if (!is_irq) reg_addr = a;
      it.is_irq = is_irq;
      it.exp    = exp;
      it.tag    = tag;
      sb_q.push_back(it);
      sample_req = 1'b1;
      @(negedge clk);
      @(posedge clk); #1;
      sample_req = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic xfer(input logic [31:0] a, input bit w, input int sz, input int m,
                       input bit err, input bit with_ce, input int irq_exp, input string tag);
      htrans = 2'b10; haddr = a; hwrite = w; hsize = 3'(sz); hmaster = MASTER_W'(m);
      hready = 1'b1; hresp = 2'b00;
      @(posedge clk); #1;
      htrans = 2'b00;
      if (!err) begin
         @(posedge clk); #1;
      end else begin
         hresp = 2'b01; hready = 1'b0; ce_in = with_ce;
         @(posedge clk); #1;
         ce_in = 1'b0; hresp = 2'b01; hready = 1'b1;
         if (irq_exp >= 0) chk(1'b1, 2'd0, 32'(irq_exp), tag);
         else begin @(posedge clk); #1; end
         hresp = 2'b00;
      end
   endtask

   task automatic ce_pulse(input int irq_exp, input string tag);
      ce_in = 1'b1;
      @(posedge clk); #1;
      ce_in = 1'b0;
      if (irq_exp >= 0) chk(1'b1, 2'd0, 32'(irq_exp), tag);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         report();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      chk(0, 2'd0, 32'h0, "R1 status after reset");
      chk(0, 2'd1, 32'h0, "R1 failing address after reset");
      chk(0, 2'd2, 32'h0, "R1 ue threshold after reset");
      chk(0, 2'd3, 32'h0, "R1 ce threshold after reset");
      chk(1, 2'd0, 32'h0, "R1 irq after reset");

      // R10 register map and threshold width
      wr(2'd2, 32'hFFFF_FF05);
      chk(0, 2'd2, 32'h05, "R10 ue threshold readback");
      wr(2'd3, 32'h0000_0103);
      chk(0, 2'd3, 32'h03, "R10 ce threshold readback");
      wr(2'd2, 32'h0); wr(2'd3, 32'h0);

      // R3 ERROR without a pending transfer is ignored
      hresp = 2'b01; hready = 1'b0;
      @(posedge clk); #1;
      hready = 1'b1;
      @(posedge clk); #1;
      hresp = 2'b00;
      chk(0, 2'd0, 32'h0, "R3 error with no transfer not counted");
      // R3 lone hready-high ERROR cycle is ignored
      htrans = 2'b10; haddr = 32'h10; hready = 1'b1;
      @(posedge clk); #1;
      htrans = 2'b00; hresp = 2'b01; hready = 1'b1;
      chk(1, 2'd0, 32'h0, "R3 second-cycle-only error no irq");
      hresp = 2'b00;
      chk(0, 2'd0, 32'h0, "R3 second-cycle-only error not counted");

      // R2 / R9 first error trips at threshold zero
      xfer(32'h1234, 1, 2, 5, 1, 0, 1, "R9 irq on first error");
      chk(1, 2'd0, 32'h0, "R9 irq drops after one cycle");
      chk(0, 2'd0, stat(1,0,1,2,5), "R2 status record");
      chk(0, 2'd1, 32'h1234, "R2 failing address");

      // R7 frozen record
      xfer(32'h2222, 0, 0, 3, 1, 0, 0, "R7 no irq while frozen");
      chk(0, 2'd0, stat(1,0,1,2,5), "R7 status frozen");
      chk(0, 2'd1, 32'h1234, "R7 failing address frozen");

      // R8 clear new-error
      wr(2'd0, 32'h1);
      chk(0, 2'd0, stat(0,0,1,2,5), "R8 NE cleared");

      // R2 pipelined transfers: B address overlaps A data phase
      htrans = 2'b10; haddr = 32'hA0; hwrite = 0; hsize = 3'd1; hmaster = 4'd1;
      @(posedge clk); #1;
      haddr = 32'hB0; hwrite = 1; hsize = 3'd3; hmaster = 4'd2;
      @(posedge clk); #1;
      htrans = 2'b00; hresp = 2'b01; hready = 1'b0;
      @(posedge clk); #1;
      hready = 1'b1;
      chk(1, 2'd0, 32'h1, "R2 pipelined error irq");
      hresp = 2'b00;
      chk(0, 2'd0, stat(1,0,1,3,2), "R2 pipelined status record");
      chk(0, 2'd1, 32'hB0, "R2 pipelined failing address");
      wr(2'd0, 32'h3);

      // R4 threshold two: third error trips
      wr(2'd2, 32'd2);
      xfer(32'h40, 0, 2, 1, 1, 0, 0, "R4 first error no trip");
      xfer(32'h44, 0, 2, 1, 1, 0, 0, "R4 second error no trip");
      xfer(32'h48, 0, 2, 1, 1, 0, 1, "R4 third error trips");
      chk(0, 2'd1, 32'h48, "R4 failing address at trip");
      // R7 an error while frozen must not advance the counter
      xfer(32'h50, 0, 2, 1, 1, 0, 0, "R7 frozen error no irq");
      wr(2'd0, 32'h1);
      xfer(32'h54, 0, 2, 1, 1, 0, 0, "R7 count restarted, 1st no trip");
      xfer(32'h58, 0, 2, 1, 1, 0, 0, "R7 frozen error not counted, 2nd no trip");
      chk(0, 2'd0, stat(0,0,0,2,1), "R4 status after two errors");
      xfer(32'h5C, 0, 2, 1, 1, 0, 1, "R4 third after restart trips");
      chk(0, 2'd1, 32'h5C, "R4 failing address second trip");
      wr(2'd0, 32'h3);

      // R5 / R6 separate counters
      wr(2'd2, 32'd1); wr(2'd3, 32'd1);
      xfer(32'h300, 1, 2, 7, 0, 0, -1, "");
      xfer(32'h304, 0, 2, 7, 1, 0, 0, "R6 one ue error no trip");
      ce_pulse(0, "R6 one ce pulse no trip");
      chk(0, 2'd0, stat(0,0,0,2,1), "R6 no flags after one of each");
      ce_pulse(1, "R5 second ce pulse trips");
      chk(0, 2'd0, stat(1,1,0,2,7), "R5 NE and CE set");
      chk(0, 2'd1, 32'h304, "R5 failing address");

      // R8 partial clear keeps monitoring frozen
      wr(2'd0, 32'h1);
      chk(0, 2'd0, stat(0,1,0,2,7), "R8 only NE cleared");
      xfer(32'h400, 0, 2, 7, 1, 0, 0, "R8 frozen while CE set");
      chk(0, 2'd1, 32'h304, "R8 record kept while CE set");
      wr(2'd0, 32'h2);
      chk(0, 2'd0, stat(0,0,0,2,7), "R8 CE cleared");
      xfer(32'h404, 1, 1, 2, 1, 0, 1, "R6 ue count kept, trips");
      chk(0, 2'd0, stat(1,0,1,1,2), "R6 ue trip sets NE only");
      wr(2'd0, 32'h3);

      // R11 simultaneous trip of both counters
      wr(2'd2, 32'd0); wr(2'd3, 32'd0);
      xfer(32'h600, 0, 2, 4, 1, 1, 1, "R11 single irq on double trip");
      chk(1, 2'd0, 32'h0, "R11 irq one cycle");
      chk(0, 2'd0, stat(1,1,0,2,4), "R11 both flags");
      wr(2'd0, 32'h3);
      wr(2'd3, 32'd1);
      xfer(32'h700, 1, 2, 4, 1, 1, 1, "R11 only ue crosses");
      chk(0, 2'd0, stat(1,0,1,2,4), "R11 only NE set");
      wr(2'd0, 32'h3);
      ce_pulse(1, "R11 ce count kept, trips");
      chk(0, 2'd0, stat(1,1,1,2,4), "R11 CE trip after kept count");

      done = 1'b1;
      @(posedge clk); #1;
      report();
   end

endmodule